// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block holds a control bit and a flag bit for each I/O select code of a 16-bit machine. It decodes the I/O instructions that change those bits and picks one interrupt source by fixed priority, where a lower code means a higher priority. It gives the CPU that source's code as the vector memory address: the CPU fetches its service entry from the word whose address equals the code.

A device is started by clearing its flag and then setting its control bit. When the device finishes, its completion strobe sets the flag. Codes 4 to 7 are system fault levels, such as power loss, parity error and protection violation. Codes 8 and up belong to I/O channels. A source that has been acknowledged stays in service until a return strobe retires it. While it is in service, it masks itself and every source with a higher number.

Top module: `vec_irq_ctl`

## Requirements
- R1: An instruction is accepted only when `io_valid` is high, bits [15:12] equal 4'b1000 and bit 10 is 1. Any other word changes no state and gives no skip. Bit 11 is ignored.
- R2: Bits [8:6] give the operation and bits [5:0] give the select code. For codes 8 and up: 0 clears control, 1 sets flag, 2 clears flag, 7 sets control, and 3, 4, 5 and 6 leave both bits alone. Instructions that name codes 1 to 7 change nothing.
- R3: When bit 9 of an accepted instruction for a code of 8 or more is set, that channel's flag is clear after the instruction, whatever the operation.
- R4: A pulse on `dev_done[c]` sets the flag of channel c (c >= 8). If an instruction clears that flag in the same cycle, the flag ends up set.
- R5: A channel is pending when its control bit, its flag and the global enable are all set. Operation 7 on code 0 sets the global enable and operation 0 on code 0 clears it.
- R6: A pulse on `sys_fault[i]` latches a pending fault at code 4+i. The latched fault is pending whether or not the global enable is set.
- R7: `irq_vec` is the lowest pending code while `irq_req` is high, and 0 otherwise.
- R8: `irq_req` is high only when the lowest pending code is lower than every code in service.
- R9: `irq_ack` while `irq_req` is high puts the vector code in service and clears a latched fault at that code.
- R10: A pulse on `svc_done` retires only the lowest-numbered code in service.
- R11: After reset, all control bits, flags, latched faults, in-service entries and the global enable are clear.
- R12: `io_skip` is high in the same cycle as an accepted instruction for a code of 8 or more when the operation is 3 and the flag is clear, or when the operation is 4 and the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O instruction issued this cycle |
| io_word | input | 16 | I/O instruction word |
| io_skip | output | 1 | Skip condition of the current test instruction |
| dev_done | input | 64 | Per-code device completion strobes |
| sys_fault | input | 4 | Fault strobes for codes 4 to 7 |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 6 | Vector address (winning code) |
| irq_ack | input | 1 | CPU takes the requested interrupt |
| svc_done | input | 1 | Return from the current service routine |

## Verification
A directed sequence nests services three deep: a channel at code 20, then a channel at code 12, then a fault at code 5. This shows whether the comparison masks the correct side and whether returns retire the lowest code first. Other cases turn the global enable off while a fault is pending, and send malformed instruction words. The H/C clear is checked against a completion strobe in the same cycle, and the skip tests are tried with the flag both set and clear. A long seeded random run mixes instructions over a small set of codes with completion strobes, faults, acknowledges and returns. Every cycle is compared against a bench model, which exposes any wrong ordering between the enable, the fault latch and the in-service mask.

// File: rtl/vec_irq_ctl.sv
module vec_irq_ctl #(
  parameter int NCODES = 64,
  parameter int SYS_LO = 4,
  parameter int NSYS   = 4,
  parameter int IO_LO  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic [15:0]       io_word,
  output logic              io_skip,
  input  logic [NCODES-1:0] dev_done,
  input  logic [NSYS-1:0]   sys_fault,
  output logic              irq_req,
  output logic [5:0]        irq_vec,
  input  logic              irq_ack,
  input  logic              svc_done
);
  logic [NCODES-1:0] ctl, flg, in_svc, pend, ctl_n, flg_n, io_mask, win_oh, svc_clr;
  logic [NSYS-1:0]   sys_p, sys_clr;
  logic              ien, svc_any, take;
  logic [5:0]        win, svc_top;

  wire       is_io  = io_valid && io_word[15:12] == 4'b1000 && io_word[10];
  wire       hc     = io_word[9];
  wire [2:0] op     = io_word[8:6];
  wire [5:0] sc     = io_word[5:0];
  wire       sel_ch = is_io && int'(sc) >= IO_LO && int'(sc) < NCODES;

  assign io_skip = sel_ch && ((op == 3'd3 && !flg[sc]) || (op == 3'd4 && flg[sc]));

  for (genvar c = 0; c < NCODES; c++) begin : g_code
    if (c >= SYS_LO && c < SYS_LO + NSYS) begin : g_sys
      assign pend[c]    = sys_p[c-SYS_LO];
      assign io_mask[c] = 1'b0;
    end else if (c >= IO_LO) begin : g_io
      assign pend[c]    = ctl[c] && flg[c] && ien;
      assign io_mask[c] = 1'b1;
    end else begin : g_none
      assign pend[c]    = 1'b0;
      assign io_mask[c] = 1'b0;
    end
  end

  always_comb begin
    win = '0;
    svc_top = '0;
    svc_any = |in_svc;
    for (int c = NCODES - 1; c >= 0; c--) begin
      if (pend[c])   win = c[5:0];
      if (in_svc[c]) svc_top = c[5:0];
    end
  end

  assign irq_req = |pend && (!svc_any || win < svc_top);
  assign irq_vec = irq_req ? win : 6'd0;
  assign take    = irq_req && irq_ack;
  assign win_oh  = take ? (NCODES'(1) << win) : '0;
  assign svc_clr = (svc_done && svc_any) ? (NCODES'(1) << svc_top) : '0;

  for (genvar i = 0; i < NSYS; i++) begin : g_sclr
    assign sys_clr[i] = take && int'(win) == SYS_LO + i;
  end

  always_comb begin
    ctl_n = ctl;
    flg_n = flg;
    if (sel_ch) begin
      case (op)
        3'd0: ctl_n[sc] = 1'b0;
        3'd1: flg_n[sc] = 1'b1;
        3'd2: flg_n[sc] = 1'b0;
        3'd7: ctl_n[sc] = 1'b1;
        default: ;
      endcase
      if (hc) flg_n[sc] = 1'b0;
    end
    flg_n = flg_n | (dev_done & io_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '0;
      flg    <= '0;
      in_svc <= '0;
      sys_p  <= '0;
      ien    <= 1'b0;
    end else begin
      ctl    <= ctl_n;
      flg    <= flg_n;
      in_svc <= (in_svc & ~svc_clr) | win_oh;
      sys_p  <= (sys_p & ~sys_clr) | sys_fault;
      if (is_io && sc == 6'd0) begin
        if (op == 3'd7) ien <= 1'b1;
        else if (op == 3'd0) ien <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk #(
  parameter int NCODES = 64,
  parameter int SYS_LO = 4,
  parameter int IO_LO  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_req,
  input logic [5:0]        irq_vec,
  input logic              irq_ack,
  input logic              svc_done,
  input logic              ien,
  input logic [NCODES-1:0] in_svc
);
  logic [NCODES-1:0] at_or_below;
  assign at_or_below = (NCODES'(1) << ({1'b0, irq_vec} + 7'd1)) - NCODES'(1);

  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> int'(irq_vec) >= SYS_LO);

  // R5
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ien) |-> int'(irq_vec) < IO_LO);

  // R8
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (in_svc & at_or_below) == '0);

  // R9
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> in_svc[$past(irq_vec)]);

  // R10
  retire_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && in_svc != '0 && !(irq_req && irq_ack))
      |=> $countones(in_svc) == $countones($past(in_svc)) - 1);

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_req);
endmodule

bind vec_irq_ctl vec_irq_chk #(.NCODES(NCODES), .SYS_LO(SYS_LO), .IO_LO(IO_LO)) chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .svc_done(svc_done), .ien(ien), .in_svc(in_svc)
);

// File: tb/vec_irq_ctl_test.sv
module vec_irq_ctl_test;
  localparam int N = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic io_valid = 1'b0, irq_ack = 1'b0, svc_done = 1'b0;
  logic [15:0] io_word = '0;
  logic [N-1:0] dev_done = '0;
  logic [3:0] sys_fault = '0;
  logic io_skip, irq_req;
  logic [5:0] irq_vec;
  int checks = 0, errors = 0, cyc = 0;

  logic [N-1:0] ctl_m = '0, flg_m = '0, in_m = '0;
  logic [3:0] sys_m = '0;
  logic ien_m = 1'b0;

  vec_irq_ctl uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] mkw(input int op, input bit hc, input int code);
    return {4'b1000, 1'b0, 1'b1, hc, 3'(op), 6'(code)};
  endfunction

  function automatic bit pend_m(input int c);
    if (c >= 4 && c < 8) return sys_m[c-4];
    if (c >= 8) return ctl_m[c] && flg_m[c] && ien_m;
    return 1'b0;
  endfunction

  function automatic int low_pend();
    for (int c = 0; c < N; c++) if (pend_m(c)) return c;
    return -1;
  endfunction

  function automatic int low_svc();
    for (int c = 0; c < N; c++) if (in_m[c]) return c;
    return N;
  endfunction

  function automatic bit exp_req();
    int w = low_pend();
    return w >= 0 && w < low_svc();
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] w, input logic [N-1:0] dd,
                      input logic [3:0] sf, input logic ak, input logic sd, input string tag);
    bit acc, tk, esk;
    int code, op, win, ls;
    io_valid = v; io_word = w; dev_done = dd; sys_fault = sf; irq_ack = ak; svc_done = sd;
    #1;
    acc  = v && w[15:12] == 4'b1000 && w[10];
    code = int'(w[5:0]);
    op   = int'(w[8:6]);
    esk  = acc && code >= 8 && ((op == 3 && !flg_m[code]) || (op == 4 && flg_m[code]));
    chk(io_skip === esk, {tag, " R12 skip"}, int'(io_skip), int'(esk));
    tk  = exp_req() && ak;
    win = low_pend();
    ls  = low_svc();
    if (acc && code >= 8) begin
      case (op)
        0: ctl_m[code] = 1'b0;
        1: flg_m[code] = 1'b1;
        2: flg_m[code] = 1'b0;
        7: ctl_m[code] = 1'b1;
        default: ;
      endcase
      if (w[9]) flg_m[code] = 1'b0;
    end
    if (acc && code == 0) begin
      if (op == 7) ien_m = 1'b1;
      else if (op == 0) ien_m = 1'b0;
    end
    for (int c = 8; c < N; c++) if (dd[c]) flg_m[c] = 1'b1;
    if (sd && ls < N) in_m[ls] = 1'b0;
    if (tk) begin
      in_m[win] = 1'b1;
      if (win >= 4 && win < 8) sys_m[win-4] = 1'b0;
    end
    sys_m = sys_m | sf;
    @(negedge clk);
    io_valid = 1'b0; irq_ack = 1'b0; svc_done = 1'b0; dev_done = '0; sys_fault = '0;
    #1;
    chk(irq_req === exp_req(), {tag, " R8 req"}, int'(irq_req), int'(exp_req()));
    if (exp_req())
      chk(int'(irq_vec) == low_pend(), {tag, " R7 vec"}, int'(irq_vec), low_pend());
    else
      chk(irq_vec == 6'd0, {tag, " R7 idle vec"}, int'(irq_vec), 0);
  endtask

  task automatic ins(input int op, input bit hc, input int code, input string tag);
    step(1'b1, mkw(op, hc, code), '0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic done(input int code, input string tag);
    step(1'b0, '0, N'(1) << code, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic expect_irq(input bit r, input int v, input string tag);
    chk(irq_req === r, {tag, " req"}, int'(irq_req), int'(r));
    if (r) chk(int'(irq_vec) == v, {tag, " vec"}, int'(irq_vec), v);
  endtask

  int codes[8] = '{0, 8, 9, 10, 11, 40, 63, 5};

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    expect_irq(1'b0, 0, "R11 reset");
    chk(io_skip === 1'b0, "R11 reset skip", int'(io_skip), 0);

    ins(7, 0, 0, "R5 enable");
    ins(7, 0, 20, "R2 set ctl 20");
    done(20, "R4 done 20");
    expect_irq(1'b1, 20, "R5 ch20 pending");
    step(1'b0, '0, '0, '0, 1'b1, 1'b0, "R9 ack 20");
    expect_irq(1'b0, 0, "R8 self mask 20");
    ins(7, 0, 30, "R2 set ctl 30");
    done(30, "R4 done 30");
    expect_irq(1'b0, 0, "R8 lower prio 30 masked");
    ins(7, 0, 12, "R2 set ctl 12");
    done(12, "R4 done 12");
    expect_irq(1'b1, 12, "R8 nest 12");
    step(1'b0, '0, '0, 4'b0010, 1'b1, 1'b0, "R9 ack 12 fault 5");
    expect_irq(1'b1, 5, "R6 fault 5 nests");
    ins(0, 0, 0, "R5 disable");
    expect_irq(1'b1, 5, "R6 fault ignores enable");
    step(1'b0, '0, '0, '0, 1'b1, 1'b0, "R9 ack 5");
    expect_irq(1'b0, 0, "R9 fault latch cleared");
    step(1'b0, '0, '0, '0, 1'b0, 1'b1, "R10 retire 5");
    expect_irq(1'b0, 0, "R5 disabled channels silent");
    ins(7, 0, 0, "R5 re-enable");
    expect_irq(1'b0, 0, "R8 12 still in service");
    step(1'b0, '0, '0, '0, 1'b0, 1'b1, "R10 retire 12");
    expect_irq(1'b1, 12, "R10 lowest retired first");
    ins(5, 1, 12, "R3 hc clears flag 12");
    expect_irq(1'b0, 0, "R3 flag 12 gone, 20 in service");
    ins(4, 0, 30, "R12 skip flag set");
    ins(3, 0, 30, "R12 no skip flag set");
    step(1'b1, 16'h9000 | mkw(2, 0, 30), '0, '0, 1'b0, 1'b0, "R1 bad prefix");
    step(1'b1, mkw(2, 0, 30) & ~16'h0400, '0, '0, 1'b0, 1'b0, "R1 bit10 clear");
    step(1'b0, mkw(2, 0, 30), '0, '0, 1'b0, 1'b0, "R1 not valid");
    ins(4, 0, 30, "R1 flag 30 kept");
    step(1'b1, mkw(2, 0, 30), N'(1) << 30, '0, 1'b0, 1'b0, "R4 done wins over clear");
    ins(4, 0, 30, "R4 flag 30 still set");
    ins(7, 0, 6, "R2 low code ignored");
    ins(1, 0, 3, "R2 low code flag ignored");
    step(1'b0, '0, '0, '0, 1'b0, 1'b1, "R10 retire 20");
    expect_irq(1'b1, 20, "R10 20 refires");

    for (int k = 0; k < 4000; k++) begin
      bit v = ($urandom % 3) == 0;
      int c = codes[$urandom % 8];
      logic [15:0] w = mkw(int'($urandom % 8), ($urandom % 5) == 0, c);
      logic [N-1:0] dd = '0;
      logic [3:0] sf = '0;
      if (($urandom % 4) == 0) dd[codes[1 + $urandom % 6]] = 1'b1;
      if (($urandom % 60) == 0) sf[$urandom % 4] = 1'b1;
      if (($urandom % 20) == 0) w[15:12] = 4'($urandom);
      step(v, w, dd, sf, ($urandom % 3) == 0, ($urandom % 4) == 0, "R2 R4 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule